// File: doc/BRIEF.md
# Coprocessor Pipeline Follower

This block is the front end of an external coprocessor that runs in lock-step with a host CPU pipeline. The host puts a 32-bit instruction word on a bus. The block captures it into its own decode slot and moves it through execute, memory and write-back slots. All slots move only on clock edges at which the host's step qualifier is high. From the decode slot the block answers with a 2-bit handshake code: it declines the instruction, stalls it, asks for another word, or marks the final word.

Load and store transfers may span several 32-bit words. Each word becomes its own beat through the pipeline and targets the next register of a small internal register file. Three host signals decide whether a beat commits:
- an execute-stage pass flag,
- a memory-stage late cancel,
- a write-back abort.

Loads take words from the data-in bus as they retire. Stores present register contents on the data-out bus while their beat sits in write-back.

The instruction fields are:
- bits [21:20]: operation. 00 sets a register from the 8-bit immediate, 01 is a load, 10 is a store, and 11 is unrecognised.
- bits [15:12]: first register.
- bits [11:8]: coprocessor number.
- bits [7:0]: immediate value.

Top module: `cop_follower`

## Requirements
- R1: After reset every slot is empty, hs_dec and hs_ex both read ABSENT (2'b10), data_out is zero, and every register reads zero.
- R2: A claimed set-register instruction (op 00) receives LAST (2'b11) in decode. While its beat sits in execute, hs_ex shows that same code. The zero-extended immediate lands in the target register.
- R3: An instruction whose bits [11:8] differ from the configured ID (default 5), or whose op is 11, receives ABSENT and changes no register.
- R4: While iface_en is low, hs_dec and hs_ex both read ABSENT, and a decoded instruction is dropped. Beats already issued still complete.
- R5: With step_en low, every slot holds its contents, both handshake outputs hold, and the instruction bus is ignored.
- R6: A beat for which pass_ex is low at the edge that moves it out of execute is dropped without effect.
- R7: A beat for which cancel_mem is high at the edge that moves it out of the memory slot is discarded without effect.
- R8: A load beat retiring with abort_wb high does not write the register file. abort_wb has no effect on a set-register beat.
- R9: A load with burst count N ≥ 1 receives GO (2'b01) for N−1 enabled cycles and then LAST. Beat k writes register (first + k) mod NREG with the data_in word present at its retiring edge. A burst count of 0 is treated as one word.
- R10: A store with burst count N drives data_out with register (first + k) mod NREG while beat k is in write-back, one word per enabled cycle. Otherwise data_out is zero.
- R11: While a beat in execute, memory or write-back will write the register that the decode beat targets, hs_dec reads WAIT (2'b00). In that case the decode slot holds and execute receives a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iface_en | input | 1 | Interface enable; low forces ABSENT responses |
| step_en | input | 1 | Host pipeline advance qualifier |
| instr_vld | input | 1 | Instruction bus carries an instruction |
| instr_in | input | 32 | Instruction word |
| burst_in | input | 4 | Word count for load/store transfers |
| pass_ex | input | 1 | Execute-stage pass flag |
| cancel_mem | input | 1 | Late cancel for the memory slot |
| abort_wb | input | 1 | Write-back abort for loads |
| data_in | input | DW | Load data from host |
| data_out | output | DW | Store data to host |
| hs_dec | output | 2 | Decode-stage handshake code |
| hs_ex | output | 2 | Handshake code of the beat in execute |

## Verification
The follower is driven with single-beat set-register writes, multi-word loads that wrap around the register file, multi-word stores, and a zero burst count. Comparing the GO/LAST sequence with the retired data shows whether beats and data words stay paired one per enabled cycle. Each commit filter (pass, cancel, abort, interface off, ID mismatch) gets its own directed run, with a register readback through a store. The readback shows whether a beat was dropped or committed, and confirms that abort spares set-register beats. Back-to-back dependent instructions and stalls on step_en show whether WAIT and hold freeze the right slots without losing or duplicating a beat.

// File: rtl/cop_pkg.sv
package cop_pkg;

  typedef enum logic [1:0] {
    HS_WAIT   = 2'b00,
    HS_GO     = 2'b01,
    HS_ABSENT = 2'b10,
    HS_LAST   = 2'b11
  } hs_t;

  typedef enum logic [1:0] {
    K_SET   = 2'b00,
    K_LOAD  = 2'b01,
    K_STORE = 2'b10,
    K_NONE  = 2'b11
  } kind_t;

  typedef struct packed {
    logic       vld;
    kind_t      kind;
    logic [3:0] idx;
    hs_t        code;
    logic [7:0] imm;
  } beat_t;

  function automatic kind_t op_of(logic [31:0] w);
    return kind_t'(w[21:20]);
  endfunction

  function automatic logic [3:0] cp_of(logic [31:0] w);
    return w[11:8];
  endfunction

  function automatic logic [3:0] rd_of(logic [31:0] w);
    return w[15:12];
  endfunction

  function automatic logic [7:0] imm_of(logic [31:0] w);
    return w[7:0];
  endfunction

  // number of beats an instruction issues
  function automatic logic [4:0] beats_of(kind_t k, logic [3:0] b);
    if (k == K_SET || b == 4'd0) return 5'd1;
    return {1'b0, b};
  endfunction

  function automatic logic writes_reg(kind_t k);
    return (k == K_SET) || (k == K_LOAD);
  endfunction

endpackage

// File: rtl/cop_decode.sv
module cop_decode
  import cop_pkg::*;
#(
  parameter int NREG  = 8,
  parameter logic [3:0] CP_ID = 4'd5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iface_en,
  input  logic            step_en,
  input  logic            instr_vld,
  input  logic [31:0]     instr_in,
  input  logic [3:0]      burst_in,
  input  logic [NREG-1:0] pend_mask,
  output hs_t             hs,
  output beat_t           beat,
  output logic            dec_valid
);
  localparam int RAW = (NREG > 1) ? $clog2(NREG) : 1;

  logic        dv;
  logic [31:0] dw;
  logic [3:0]  db;
  logic [3:0]  wcnt;

  kind_t          k;
  logic [3:0]     tgt;
  logic [RAW-1:0] tix;
  logic [4:0]     nb;
  logic           claim;

  always_comb begin
    k     = op_of(dw);
    nb    = beats_of(k, db);
    tgt   = rd_of(dw) + wcnt;
    tix   = tgt[RAW-1:0];
    claim = dv && (cp_of(dw) == CP_ID) && (k != K_NONE);
    if (!iface_en || !claim)            hs = HS_ABSENT;
    else if (pend_mask[tix])            hs = HS_WAIT;
    else if (({1'b0, wcnt} + 5'd1) < nb) hs = HS_GO;
    else                                hs = HS_LAST;

    beat.vld  = (hs == HS_GO) || (hs == HS_LAST);
    beat.kind = k;
    beat.idx  = tgt;
    beat.code = hs;
    beat.imm  = imm_of(dw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv   <= 1'b0;
      dw   <= '0;
      db   <= '0;
      wcnt <= '0;
    end else if (step_en) begin
      case (hs)
        HS_GO:   wcnt <= wcnt + 4'd1;
        HS_WAIT: wcnt <= wcnt;
        default: begin
          dv   <= instr_vld;
          dw   <= instr_in;
          db   <= burst_in;
          wcnt <= '0;
        end
      endcase
    end
  end

  assign dec_valid = dv;

endmodule

// File: rtl/cop_stages.sv
module cop_stages
  import cop_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic            pass_ex,
  input  logic            cancel_mem,
  input  beat_t           iss,
  output beat_t           ex,
  output beat_t           mem,
  output beat_t           wb,
  output logic [NREG-1:0] pend_mask
);
  localparam int RAW = (NREG > 1) ? $clog2(NREG) : 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex  <= '0;
      mem <= '0;
      wb  <= '0;
    end else if (step_en) begin
      ex      <= iss;
      mem     <= ex;
      mem.vld <= ex.vld && pass_ex;
      wb      <= mem;
      wb.vld  <= mem.vld && !cancel_mem;
    end
  end

  function automatic logic hits(beat_t b, int r);
    return b.vld && writes_reg(b.kind) && (b.idx[RAW-1:0] == RAW'(r));
  endfunction

  for (genvar r = 0; r < NREG; r++) begin : g_pend
    assign pend_mask[r] = hits(ex, r) || hits(mem, r) || hits(wb, r);
  end

endmodule

// File: rtl/cop_regfile.sv
module cop_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int RAW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RAW-1:0] widx,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] ridx,
  output logic [DW-1:0]  rdata
);
  logic [NREG-1:0][DW-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  regs <= '0;
    else if (we) regs[widx] <= wdata;
  end

  assign rdata = regs[ridx];

endmodule

// File: rtl/cop_follower.sv
module cop_follower
  import cop_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int DW    = 32,
  parameter logic [3:0] CP_ID = 4'd5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iface_en,
  input  logic          step_en,
  input  logic          instr_vld,
  input  logic [31:0]   instr_in,
  input  logic [3:0]    burst_in,
  input  logic          pass_ex,
  input  logic          cancel_mem,
  input  logic          abort_wb,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic [1:0]    hs_dec,
  output logic [1:0]    hs_ex
);
  localparam int RAW = (NREG > 1) ? $clog2(NREG) : 1;

  hs_t             dec_hs;
  beat_t           iss_b, ex_b, mem_b, wb_b;
  logic [NREG-1:0] pend;
  logic [DW-1:0]   rf_rdata, rf_wdata;

  // named internal events for the checker
  logic dec_valid_w, ex_valid_w, mem_valid_w, wb_valid_w, wb_load_w, rf_we_w;

  cop_decode #(.NREG(NREG), .CP_ID(CP_ID)) u_dec (
    .clk(clk), .rst_n(rst_n), .iface_en(iface_en), .step_en(step_en),
    .instr_vld(instr_vld), .instr_in(instr_in), .burst_in(burst_in),
    .pend_mask(pend), .hs(dec_hs), .beat(iss_b), .dec_valid(dec_valid_w)
  );

  cop_stages #(.NREG(NREG)) u_stg (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .pass_ex(pass_ex),
    .cancel_mem(cancel_mem), .iss(iss_b), .ex(ex_b), .mem(mem_b), .wb(wb_b),
    .pend_mask(pend)
  );

  assign ex_valid_w  = ex_b.vld;
  assign mem_valid_w = mem_b.vld;
  assign wb_valid_w  = wb_b.vld;
  assign wb_load_w   = wb_b.vld && (wb_b.kind == K_LOAD);
  assign rf_we_w     = step_en && wb_b.vld &&
                       ((wb_b.kind == K_SET) || ((wb_b.kind == K_LOAD) && !abort_wb));
  assign rf_wdata    = (wb_b.kind == K_SET) ? DW'(wb_b.imm) : data_in;

  cop_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we_w), .widx(wb_b.idx[RAW-1:0]),
    .wdata(rf_wdata), .ridx(wb_b.idx[RAW-1:0]), .rdata(rf_rdata)
  );

  assign data_out = (wb_b.vld && wb_b.kind == K_STORE) ? rf_rdata : '0;
  assign hs_dec   = dec_hs;
  assign hs_ex    = (iface_en && ex_b.vld) ? ex_b.code : HS_ABSENT;

endmodule

// File: rtl/cop_follower_chk.sv
module cop_follower_chk
  import cop_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       iface_en,
  input logic       step_en,
  input logic       pass_ex,
  input logic       cancel_mem,
  input logic       abort_wb,
  input logic [1:0] hs_dec,
  input logic [1:0] hs_ex,
  input logic       dec_valid,
  input logic       ex_valid,
  input logic       mem_valid,
  input logic       wb_valid,
  input logic       wb_load,
  input logic       rf_we
);

  p_empty_absent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> hs_dec == HS_ABSENT);

  p_off_absent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !iface_en |-> (hs_dec == HS_ABSENT) && (hs_ex == HS_ABSENT));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(dec_valid) && $stable(ex_valid) &&
                 $stable(mem_valid) && $stable(wb_valid));

  p_pass_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !pass_ex) |=> !mem_valid);

  p_cancel_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cancel_mem) |=> !wb_valid);

  p_abort_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_load && abort_wb) |-> !rf_we);

  p_go_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && hs_dec == HS_GO) |=> dec_valid);

  p_wait_bubble_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && hs_dec == HS_WAIT) |=> !ex_valid && dec_valid);

endmodule

bind cop_follower cop_follower_chk u_chk (
  .clk(clk), .rst_n(rst_n), .iface_en(iface_en), .step_en(step_en),
  .pass_ex(pass_ex), .cancel_mem(cancel_mem), .abort_wb(abort_wb),
  .hs_dec(hs_dec), .hs_ex(hs_ex), .dec_valid(dec_valid_w),
  .ex_valid(ex_valid_w), .mem_valid(mem_valid_w), .wb_valid(wb_valid_w),
  .wb_load(wb_load_w), .rf_we(rf_we_w)
);

// File: tb/cop_follower_test.sv
`timescale 1ns/1ps
module cop_follower_test;
  localparam logic [3:0] CPN = 4'd5;
  localparam logic [1:0] ABS = 2'b10, WT = 2'b00, GO = 2'b01, LST = 2'b11;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        iface_en = 1'b1, step_en = 1'b1, instr_vld = 1'b0;
  logic [31:0] instr_in = '0;
  logic [3:0]  burst_in = '0;
  logic        pass_ex = 1'b1, cancel_mem = 1'b0, abort_wb = 1'b0;
  logic [31:0] data_in = '0, data_out;
  logic [1:0]  hs_dec, hs_ex;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cop_follower uut (
    .clk(clk), .rst_n(rst_n), .iface_en(iface_en), .step_en(step_en),
    .instr_vld(instr_vld), .instr_in(instr_in), .burst_in(burst_in),
    .pass_ex(pass_ex), .cancel_mem(cancel_mem), .abort_wb(abort_wb),
    .data_in(data_in), .data_out(data_out), .hs_dec(hs_dec), .hs_ex(hs_ex)
  );

  function automatic logic [31:0] mk(logic [1:0] op, logic [3:0] cp,
                                     logic [3:0] rd, logic [7:0] imm);
    return {10'd0, op, 4'd0, rd, cp, imm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic issue(logic [31:0] w, logic [3:0] b);
    instr_in = w; burst_in = b; instr_vld = 1'b1;
    tick();
    instr_vld = 1'b0;
  endtask

  // single-word store: value appears on data_out three edges after capture
  task automatic read_reg(logic [3:0] idx, logic [31:0] exp, string req);
    issue(mk(2'b10, CPN, idx, 8'h00), 4'd1);
    idle(3);
    check(req, data_out, exp);
    tick();
  endtask

  task automatic t_reset();
    check("R1 hs_dec", {30'd0, hs_dec}, {30'd0, ABS});
    check("R1 hs_ex", {30'd0, hs_ex}, {30'd0, ABS});
    check("R1 data_out", data_out, 32'd0);
    read_reg(4'd3, 32'd0, "R1 reg3");
  endtask

  task automatic t_setreg();
    issue(mk(2'b00, CPN, 4'd2, 8'h5A), 4'd0);
    check("R2 hs_dec LAST", {30'd0, hs_dec}, {30'd0, LST});
    tick();
    check("R2 hs_ex LAST", {30'd0, hs_ex}, {30'd0, LST});
    idle(4);
    read_reg(4'd2, 32'h5A, "R2 reg2");
  endtask

  task automatic t_cpmis();
    issue(mk(2'b00, 4'd3, 4'd4, 8'h11), 4'd0);
    check("R3 mismatch ABSENT", {30'd0, hs_dec}, {30'd0, ABS});
    tick();
    check("R3 no beat", {30'd0, hs_ex}, {30'd0, ABS});
    issue(mk(2'b11, CPN, 4'd4, 8'h22), 4'd0);
    check("R3 op11 ABSENT", {30'd0, hs_dec}, {30'd0, ABS});
    idle(5);
    read_reg(4'd4, 32'd0, "R3 reg4");
  endtask

  task automatic t_iface();
    iface_en = 1'b0;
    issue(mk(2'b00, CPN, 4'd5, 8'h77), 4'd0);
    check("R4 off dec", {30'd0, hs_dec}, {30'd0, ABS});
    tick();
    iface_en = 1'b1;
    check("R4 dropped", {30'd0, hs_ex}, {30'd0, ABS});
    issue(mk(2'b00, CPN, 4'd6, 8'h21), 4'd0);
    tick();
    iface_en = 1'b0;
    #1;
    check("R4 off ex", {30'd0, hs_ex}, {30'd0, ABS});
    iface_en = 1'b1;
    #1;
    check("R4 on ex", {30'd0, hs_ex}, {30'd0, LST});
    idle(4);
    read_reg(4'd5, 32'd0, "R4 reg5");
    read_reg(4'd6, 32'h21, "R4 reg6");
  endtask

  task automatic t_hold();
    issue(mk(2'b00, CPN, 4'd7, 8'h3C), 4'd0);
    step_en = 1'b0;
    instr_in = mk(2'b00, CPN, 4'd7, 8'hFF); instr_vld = 1'b1;
    idle(3);
    check("R5 dec held", {30'd0, hs_dec}, {30'd0, LST});
    check("R5 ex empty", {30'd0, hs_ex}, {30'd0, ABS});
    instr_vld = 1'b0;
    step_en = 1'b1;
    tick();
    step_en = 1'b0;
    idle(2);
    check("R5 ex held", {30'd0, hs_ex}, {30'd0, LST});
    step_en = 1'b1;
    idle(4);
    read_reg(4'd7, 32'h3C, "R5 reg7");
  endtask

  task automatic t_pass();
    issue(mk(2'b00, CPN, 4'd1, 8'h99), 4'd0);
    tick();
    pass_ex = 1'b0;
    tick();
    pass_ex = 1'b1;
    idle(4);
    read_reg(4'd1, 32'd0, "R6 reg1");
  endtask

  task automatic t_cancel();
    issue(mk(2'b00, CPN, 4'd1, 8'h44), 4'd0);
    idle(2);
    cancel_mem = 1'b1;
    tick();
    cancel_mem = 1'b0;
    idle(4);
    read_reg(4'd1, 32'd0, "R7 reg1");
  endtask

  task automatic t_abort();
    data_in = 32'hDEADBEEF;
    issue(mk(2'b01, CPN, 4'd3, 8'h00), 4'd1);
    idle(3);
    abort_wb = 1'b1;
    tick();
    abort_wb = 1'b0;
    idle(3);
    read_reg(4'd3, 32'd0, "R8 load aborted");
    issue(mk(2'b00, CPN, 4'd3, 8'h12), 4'd0);
    idle(3);
    abort_wb = 1'b1;
    tick();
    abort_wb = 1'b0;
    idle(3);
    read_reg(4'd3, 32'h12, "R8 set ignores abort");
  endtask

  task automatic t_burst_load();
    logic [31:0] base = 32'hA500_0000;
    data_in = base;
    issue(mk(2'b01, CPN, 4'd6, 8'h00), 4'd3);
    check("R9 w0 GO", {30'd0, hs_dec}, {30'd0, GO});
    for (int j = 1; j <= 6; j++) begin
      data_in = base + j;
      tick();
      if (j == 1) check("R9 w1 GO", {30'd0, hs_dec}, {30'd0, GO});
      if (j == 2) check("R9 w2 LAST", {30'd0, hs_dec}, {30'd0, LST});
      if (j == 2) check("R9 ex GO", {30'd0, hs_ex}, {30'd0, GO});
      if (j == 3) check("R9 ex LAST", {30'd0, hs_ex}, {30'd0, LST});
    end
    idle(4);
    read_reg(4'd6, base + 32'd4, "R9 reg6");
    read_reg(4'd7, base + 32'd5, "R9 reg7");
    read_reg(4'd0, base + 32'd6, "R9 reg0 wrap");
    data_in = 32'h0BAD_F00D;
    issue(mk(2'b01, CPN, 4'd2, 8'h00), 4'd0);
    check("R9 burst0 LAST", {30'd0, hs_dec}, {30'd0, LST});
    idle(5);
    read_reg(4'd2, 32'h0BAD_F00D, "R9 burst0 reg2");
  endtask

  task automatic t_burst_store();
    logic [31:0] base = 32'hA500_0000;
    issue(mk(2'b10, CPN, 4'd6, 8'h00), 4'd3);
    check("R10 w0 GO", {30'd0, hs_dec}, {30'd0, GO});
    for (int j = 1; j <= 6; j++) begin
      tick();
      if (j == 3) check("R10 word0", data_out, base + 32'd4);
      if (j == 4) check("R10 word1", data_out, base + 32'd5);
      if (j == 5) check("R10 word2", data_out, base + 32'd6);
      if (j == 6) check("R10 idle zero", data_out, 32'd0);
    end
  endtask

  task automatic t_wait();
    issue(mk(2'b00, CPN, 4'd1, 8'h66), 4'd0);
    issue(mk(2'b10, CPN, 4'd1, 8'h00), 4'd1);
    check("R11 WAIT ex", {30'd0, hs_dec}, {30'd0, WT});
    tick();
    check("R11 WAIT mem", {30'd0, hs_dec}, {30'd0, WT});
    check("R11 bubble", {30'd0, hs_ex}, {30'd0, ABS});
    tick();
    check("R11 WAIT wb", {30'd0, hs_dec}, {30'd0, WT});
    tick();
    check("R11 released", {30'd0, hs_dec}, {30'd0, LST});
    idle(3);
    check("R11 store data", data_out, 32'h66);
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setreg();
    t_cpmis();
    t_iface();
    t_hold();
    t_pass();
    t_cancel();
    t_abort();
    t_burst_load();
    t_burst_store();
    t_wait();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule